// File: doc/BRIEF.md
# Injected Conversion Group Sequencer

This block runs a short, high-priority group of up to four analog conversions. Software writes a configuration word that holds a 2-bit length code and four 5-bit channel-select slots. When a trigger arrives, the sequencer takes a snapshot of that word. It then walks through the active slots and, for each one, issues a request to a converter over a request/acknowledge handshake. Every returned value goes into one of four 16-bit result registers, which can only be read.

A group shorter than four is aligned to the top of the slot list. The walk starts at slot index 3 minus the length code and rises to slot 3, so slot 3 is always converted and slot 0 is used only by a full group. A slot that names a channel outside 0..17 is skipped: the sequencer raises an error pulse and moves on. When the last slot has been handled, the sequencer emits a one-cycle end-of-group pulse and sets a sticky done flag.

Top module: `inj_seq_top`

## Requirements
- R1: With length code L (configuration bits 21:20), a group visits exactly L+1 slots.
- R2: Slots are visited in ascending order, from slot index 3−L up to slot 3. A full group runs 0,1,2,3 and L=0 runs slot 3 alone.
- R3: The configuration word holds slot n in bits 5n+4:5n (n = 0..3) and the length code in bits 21:20. Reading the word back returns what was written, with bits 31:22 as zero.
- R4: A slot whose channel code is above 17 issues no request. It produces a one-cycle chan_err pulse, and the group carries on with the next slot.
- R5: The k-th conversion performed in a group (k from 0) is stored in result register k. Result registers that the group does not reach keep their earlier contents.
- R6: A result read returns the stored 16-bit value in bits 15:0 with bits 31:16 as zero. The value appears one clock after res_sel is presented.
- R7: The configuration is sampled when a trigger is accepted. A write made during an active group takes effect only from the next trigger.
- R8: A trigger that arrives while busy is high is ignored. It causes no extra request and no extra end-of-group pulse.
- R9: After the last result is stored, eog_pulse is high for exactly one cycle and done_flag becomes 1. done_flag stays at 1 until done_clr is asserted.
- R10: conv_req stays high, and conv_chan stays unchanged, until the converter asserts conv_ack. The request then drops on the next clock.
- R11: After reset the block is idle: no request, done_flag at 0, configuration and all result registers at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_wr_data | input | 32 | Configuration word to write |
| cfg_rd_data | output | 32 | Configuration word readback |
| trig | input | 1 | Group start trigger |
| conv_req | output | 1 | Conversion request to the converter |
| conv_chan | output | 5 | Channel number of the current request |
| conv_ack | input | 1 | Converter acknowledge; data valid |
| conv_data | input | 16 | Conversion result from the converter |
| res_sel | input | 2 | Result register select |
| res_data | output | 32 | Selected result, registered |
| eog_pulse | output | 1 | One-cycle end-of-group pulse |
| done_flag | output | 1 | Sticky group-done flag |
| done_clr | input | 1 | Clears done_flag |
| chan_err | output | 1 | One-cycle pulse for a skipped out-of-range slot |
| busy | output | 1 | A group is in progress |

## Verification
The assertions rely on one assumption about the converter: it raises conv_ack only while conv_req is high, and only for a single cycle. The request-stability and skip properties depend on this. The bench's converter stub waits for a request, holds off a varying latency of 0 to 3 cycles, and then pulses the acknowledge once. After that it waits for the request to drop before it watches for another one. Triggers and configuration writes sent during a group test R7 and R8. They never touch the handshake itself.

// File: rtl/inj_seq_pkg.sv
package inj_seq_pkg;
  localparam int NUM_SLOTS = 4;
  localparam int SLOT_W    = 5;
  localparam int LEN_W     = 2;
  localparam int LEN_LSB   = NUM_SLOTS * SLOT_W;
  localparam int CFG_USED  = LEN_LSB + LEN_W;
  localparam int MAX_CHAN  = 17;
  localparam int IDX_W     = $clog2(NUM_SLOTS);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_t;

  function automatic logic [SLOT_W-1:0] slot_of(input logic [31:0] cfg,
                                                input logic [IDX_W-1:0] idx);
    return cfg[idx*SLOT_W +: SLOT_W];
  endfunction
endpackage

// File: rtl/inj_cfg_reg.sv
module inj_cfg_reg
  import inj_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] cfg_q
);
  localparam logic [31:0] KEEP_MASK = (32'h1 << CFG_USED) - 32'h1;

  always_ff @(posedge clk) begin
    if (rst)        cfg_q <= '0;
    else if (wr_en) cfg_q <= wr_data & KEEP_MASK;
  end
endmodule

// File: rtl/inj_seq_ctrl.sv
module inj_seq_ctrl
  import inj_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic [31:0]       cfg,
  input  logic              conv_ack,
  input  logic              done_clr,
  output logic              conv_req,
  output logic [SLOT_W-1:0] conv_chan,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic              busy,
  output logic              eog_pulse,
  output logic              done_flag,
  output logic              chan_err
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

  seq_state_t        state;
  logic [31:0]       snap;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  cnt;
  logic [SLOT_W-1:0] cur_slot;

  assign cur_slot = slot_of(snap, idx);
  assign busy     = (state != ST_IDLE);
  assign wr_en    = (state == ST_WAIT) && conv_ack;
  assign wr_idx   = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      snap      <= '0;
      idx       <= '0;
      cnt       <= '0;
      conv_req  <= 1'b0;
      conv_chan <= '0;
      eog_pulse <= 1'b0;
      done_flag <= 1'b0;
      chan_err  <= 1'b0;
    end else begin
      eog_pulse <= 1'b0;
      chan_err  <= 1'b0;
      if (done_clr) done_flag <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (trig) begin
            snap  <= cfg;
            idx   <= LAST_IDX - cfg[LEN_LSB +: LEN_W];
            cnt   <= '0;
            state <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (cur_slot > SLOT_W'(MAX_CHAN)) begin
            chan_err <= 1'b1;
            if (idx == LAST_IDX) begin
              eog_pulse <= 1'b1;
              done_flag <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            conv_req  <= 1'b1;
            conv_chan <= cur_slot;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (conv_ack) begin
            conv_req <= 1'b0;
            cnt      <= cnt + 1'b1;
            if (idx == LAST_IDX) begin
              eog_pulse <= 1'b1;
              done_flag <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/inj_result_bank.sv
module inj_result_bank
  import inj_seq_pkg::*;
#(
  parameter int CONV_W = 16,
  parameter int RES_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [CONV_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [31:0]       rd_data
);
  logic [RES_W-1:0] wide_data;
  logic [RES_W-1:0] regs [NUM_SLOTS];

  generate
    if (CONV_W < RES_W) begin : g_pad
      assign wide_data = {{(RES_W-CONV_W){1'b0}}, wr_data};
    end else begin : g_trunc
      assign wide_data = wr_data[RES_W-1:0];
    end
  endgenerate

  generate
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_res
      always_ff @(posedge clk) begin
        if (rst)                                  regs[i] <= '0;
        else if (wr_en && wr_idx == IDX_W'(i))    regs[i] <= wide_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= {{(32-RES_W){1'b0}}, regs[rd_idx]};
  end
endmodule

// File: rtl/inj_seq_top.sv
module inj_seq_top
  import inj_seq_pkg::*;
#(
  parameter int CONV_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [31:0]       cfg_wr_data,
  output logic [31:0]       cfg_rd_data,
  input  logic              trig,
  output logic              conv_req,
  output logic [4:0]        conv_chan,
  input  logic              conv_ack,
  input  logic [CONV_W-1:0] conv_data,
  input  logic [1:0]        res_sel,
  output logic [31:0]       res_data,
  output logic              eog_pulse,
  output logic              done_flag,
  input  logic              done_clr,
  output logic              chan_err,
  output logic              busy
);
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;

  inj_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .cfg_q(cfg_rd_data)
  );

  inj_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .trig(trig), .cfg(cfg_rd_data),
    .conv_ack(conv_ack), .done_clr(done_clr),
    .conv_req(conv_req), .conv_chan(conv_chan),
    .wr_en(wr_en), .wr_idx(wr_idx), .busy(busy),
    .eog_pulse(eog_pulse), .done_flag(done_flag), .chan_err(chan_err)
  );

  inj_result_bank #(.CONV_W(CONV_W), .RES_W(16)) u_res (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(conv_data), .rd_idx(res_sel), .rd_data(res_data)
  );
endmodule

// File: rtl/inj_seq_checker.sv
module inj_seq_checker (
  input logic        clk,
  input logic        rst,
  input logic [31:0] cfg_rd_data,
  input logic        conv_req,
  input logic [4:0]  conv_chan,
  input logic        conv_ack,
  input logic [31:0] res_data,
  input logic        eog_pulse,
  input logic        done_flag,
  input logic        done_clr,
  input logic        chan_err,
  input logic        busy
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    conv_req && !conv_ack |=> conv_req && $stable(conv_chan));

  p_req_drop_r10: assert property (@(posedge clk) disable iff (rst)
    conv_req && conv_ack |=> !conv_req);

  p_chan_range_r4: assert property (@(posedge clk) disable iff (rst)
    conv_req |-> conv_chan <= 5'd17);

  p_skip_no_req_r4: assert property (@(posedge clk) disable iff (rst)
    chan_err |-> !conv_req);

  p_eog_single_r9: assert property (@(posedge clk) disable iff (rst)
    eog_pulse |=> !eog_pulse);

  p_eog_sets_done_r9: assert property (@(posedge clk) disable iff (rst)
    eog_pulse |-> done_flag);

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    done_flag && !done_clr && !eog_pulse |=> done_flag);

  p_cfg_upper_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_rd_data[31:22] == 10'd0);

  p_res_upper_r6: assert property (@(posedge clk) disable iff (rst)
    res_data[31:16] == 16'd0);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !conv_req);
endmodule

bind inj_seq_top inj_seq_checker u_chk (
  .clk(clk), .rst(rst), .cfg_rd_data(cfg_rd_data), .conv_req(conv_req),
  .conv_chan(conv_chan), .conv_ack(conv_ack), .res_data(res_data),
  .eog_pulse(eog_pulse), .done_flag(done_flag), .done_clr(done_clr),
  .chan_err(chan_err), .busy(busy)
);

// File: tb/inj_seq_top_bench.sv
module inj_seq_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic        trig = 1'b0;
  logic        conv_req;
  logic [4:0]  conv_chan;
  logic        conv_ack = 1'b0;
  logic [15:0] conv_data = '0;
  logic [1:0]  res_sel = '0;
  logic [31:0] res_data;
  logic        eog_pulse, done_flag, chan_err, busy;
  logic        done_clr = 1'b0;

  always #5 clk = ~clk;

  inj_seq_top u_inj_seq_top (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .trig(trig), .conv_req(conv_req),
    .conv_chan(conv_chan), .conv_ack(conv_ack), .conv_data(conv_data),
    .res_sel(res_sel), .res_data(res_data), .eog_pulse(eog_pulse),
    .done_flag(done_flag), .done_clr(done_clr), .chan_err(chan_err),
    .busy(busy)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [31:0] cfg_model = '0;
  int          exp_chan_q[$];
  int          data_q[$];
  int          exp_res[4];
  int          exp_err = 0;
  int          eog_cnt = 0;
  int          err_cnt = 0;
  int          stray_req = 0;
  bit          prev_req = 0;
  int          prev_chan = 0;
  int          lat = 0;
  int          seq_no = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // Per-clock monitor: request order and stability against the model queue
  always @(negedge clk) begin
    if (!rst) begin
      if (eog_pulse) eog_cnt++;
      if (chan_err)  err_cnt++;
      if (conv_req && !prev_req) begin
        if (exp_chan_q.size() == 0) begin
          stray_req++;
          check(0, "R8 unexpected request", int'(conv_chan), -1);
        end else begin
          int e;
          e = exp_chan_q.pop_front();
          check(int'(conv_chan) == e, "R2 request channel order", int'(conv_chan), e);
        end
      end else if (conv_req && prev_req) begin
        check(int'(conv_chan) == prev_chan, "R10 channel held while pending", int'(conv_chan), prev_chan);
      end
      prev_req  = conv_req;
      prev_chan = int'(conv_chan);
    end
  end

  // Converter stub
  initial begin
    forever begin
      @(negedge clk);
      if (conv_req && !conv_ack) begin
        repeat (lat) @(negedge clk);
        seq_no++;
        conv_data = 16'hA000 + 16'(conv_chan) * 16'h10 + 16'(seq_no % 16);
        data_q.push_back(int'(conv_data));
        conv_ack = 1'b1;
        @(negedge clk);
        conv_ack = 1'b0;
        lat = (lat + 1) % 4;
      end
    end
  end

  task automatic wr_cfg(input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    cfg_model = d & 32'h003F_FFFF;
  endtask

  task automatic fire();
    int l;
    l = int'(cfg_model[21:20]);
    for (int i = 3 - l; i <= 3; i++) begin
      int ch;
      ch = int'(cfg_model[i*5 +: 5]);
      if (ch <= 17) exp_chan_q.push_back(ch);
      else          exp_err++;
    end
    data_q.delete();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic wait_group(input int eog_before, input string req);
    int n;
    n = 0;
    while (eog_cnt == eog_before && n < 2000) begin @(negedge clk); n++; end
    check(eog_cnt == eog_before + 1, req, eog_cnt - eog_before, 1);
    for (int k = 0; k < data_q.size(); k++) exp_res[k] = data_q[k];
  endtask

  task automatic read_res(input int k, output int v);
    @(negedge clk); res_sel = 2'(k);
    @(negedge clk); v = int'(res_data);
  endtask

  task automatic check_results(input string req);
    for (int k = 0; k < 4; k++) begin
      int v;
      read_res(k, v);
      check(v == exp_res[k], req, v, exp_res[k]);
    end
  endtask

  task automatic run_group(input logic [31:0] c, input string tag);
    int e0, r0;
    wr_cfg(c);
    e0 = eog_cnt; r0 = err_cnt; exp_err = 0;
    fire();
    wait_group(e0, {tag, " R9 one eog pulse"});
    check(exp_chan_q.size() == 0, {tag, " R1 slots converted"}, exp_chan_q.size(), 0);
    check(err_cnt - r0 == exp_err, {tag, " R4 error pulses"}, err_cnt - r0, exp_err);
    check_results({tag, " R5 R6 result registers"});
  endtask

  function automatic logic [31:0] mk(input int l, input int s0, input int s1,
                                     input int s2, input int s3);
    return (32'(l) << 20) | (32'(s3) << 15) | (32'(s2) << 10) | (32'(s1) << 5) | 32'(s0);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) exp_res[k] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    check(conv_req == 1'b0, "R11 conv_req after reset", int'(conv_req), 0);
    check(done_flag == 1'b0, "R11 done_flag after reset", int'(done_flag), 0);
    check(busy == 1'b0, "R11 busy after reset", int'(busy), 0);
    check(cfg_rd_data == 32'd0, "R11 config after reset", int'(cfg_rd_data), 0);
    check_results("R11 results after reset");

    // R3 layout and readback masking
    wr_cfg(32'hFFC0_0000 | mk(2, 3, 7, 11, 17));
    check(cfg_rd_data == mk(2, 3, 7, 11, 17), "R3 config readback", int'(cfg_rd_data), int'(mk(2, 3, 7, 11, 17)));

    // R1 R2 full group
    run_group(mk(3, 5, 1, 17, 0), "full");
    check(done_flag == 1'b1, "R9 done set after group", int'(done_flag), 1);
    repeat (5) @(negedge clk);
    check(done_flag == 1'b1, "R9 done sticky", int'(done_flag), 1);
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
    check(done_flag == 1'b0, "R9 done cleared", int'(done_flag), 0);

    // R2 L=0 only slot 3; R5 others keep
    run_group(mk(0, 2, 3, 4, 9), "len1");
    // R2 L=1
    run_group(mk(1, 30, 31, 7, 8), "len2");
    // R4 out-of-range in middle
    run_group(mk(2, 12, 4, 20, 6), "skip");
    // R4 out-of-range last slot
    run_group(mk(3, 10, 11, 12, 25), "skiplast");
    // R4 all slots invalid: no results written
    run_group(mk(1, 0, 0, 18, 31), "allbad");

    // R7 and R8: write and retrigger during a busy group
    begin
      int e0;
      wr_cfg(mk(3, 13, 14, 15, 16));
      e0 = eog_cnt; exp_err = 0;
      fire();
      @(negedge clk);
      check(busy == 1'b1, "R8 busy during group", int'(busy), 1);
      @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_data = mk(0, 1, 1, 1, 2);
      @(negedge clk); cfg_wr_en = 1'b0;
      @(negedge clk); trig = 1'b1;
      @(negedge clk); trig = 1'b0;
      wait_group(e0, "R7 R8 group finishes once");
      check(exp_chan_q.size() == 0, "R7 old config used", exp_chan_q.size(), 0);
      repeat (40) @(negedge clk);
      check(eog_cnt == e0 + 1, "R8 no extra group", eog_cnt - e0, 1);
      check(stray_req == 0, "R8 no stray request", stray_req, 0);
      check(cfg_rd_data == mk(0, 1, 1, 1, 2), "R7 new config held", int'(cfg_rd_data), int'(mk(0, 1, 1, 1, 2)));
      cfg_model = mk(0, 1, 1, 1, 2);
      check_results("R7 R5 results from old config");
    end

    // R7 new config applies on next trigger
    run_group(mk(0, 1, 1, 1, 2), "next");

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule